// File: doc/BRIEF.md
# Switchable 8KB/16KB Cartridge Bank Mapper with Battery RAM Select

This block translates the CPU address of a cartridge slot into a ROM address. The slot spans 0x4000-0xBFFF. Software picks which 8KB ROM bank appears in each part of that range by writing a bank number into a register. The registers are reached by CPU writes into the 0x6000-0x7FFF range. Each bank register drives one 8KB window. The window occupying an address is selected by address bits 15 and 13, and the ROM address is that window's bank number (reduced modulo the ROM bank count) joined to the low 13 address bits.

A strap input chooses the window arrangement:
- **8KB arrangement:** four independent 8KB windows.
- **16KB arrangement:** two 16KB windows. Each write loads an even/odd pair of 8KB banks.

A second strap enables an 8KB battery RAM. It can be switched in place of ROM in the upper half of the slot. In that case the upper bits of the written bank byte act as the select, and only the low nibble is kept as the bank number. The block drives a RAM select and a RAM write enable. The ROM and RAM arrays sit outside this block.

Top module: `bank_mapper`

## Requirements
- R1: After reset every bank register holds 0 and no window is mapped to RAM. Any address 0x4000-0xBFFF then gives `romAddr` = {8'h00, cpuAddr[12:0]} and `sramSel` = 0.
- R2: In the 8KB arrangement, a qualified write sets one bank register, chosen by cpuAddr[15:11]. The value takes effect from the next clock cycle.
  - 5'b01100 sets the bank for window 0 (0x4000-0x5FFF).
  - 5'b01101 sets the bank for window 1 (0x6000-0x7FFF).
  - 5'b01110 sets the bank for window 2 (0x8000-0x9FFF).
  - 5'b01111 sets the bank for window 3 (0xA000-0xBFFF).
- R3: A write changes no register unless `cpuWr` and `slotSel` are both 1 in the same cycle.
- R4: For cpuAddr in 0x4000-0xBFFF, `romAddr` = {bank of the window mod ROM_BANKS, cpuAddr[12:0]}, where ROM_BANKS is a power of two. For other addresses, `romAddr` = {8'h00, cpuAddr[12:0]} and `sramSel` = 0.
- R5: In the 16KB arrangement, a qualified write of v to 0x6000-0x67FF loads bank (2v mod 256) into window 0 and bank (2v+1 mod 256) into window 1.
- R6: In the 16KB arrangement, a qualified write of v to 0x7000-0x77FF loads 2v into window 2 and 2v+1 into window 3. Writes to 0x6800-0x6FFF and 0x7800-0x7FFF change nothing.
- R7: With RAM enabled in the 8KB arrangement, a qualified write to 0x7000-0x7FFF maps both windows 2 and 3 to RAM when data[7:4] is nonzero, and back to ROM when it is zero. With RAM enabled, every bank register stores only data[3:0] in either arrangement.
- R8: With RAM enabled in the 16KB arrangement, a qualified write to 0x7000-0x77FF maps window 2 to RAM when data[4] is 1, and to ROM otherwise. Window 3 is then ROM.
- R9: `sramWe` is 1 exactly when `sramSel` and `cpuWr` are both 1 in the same cycle. `sramSel` requires `slotSel` = 1.
- R10: With RAM disabled, `sramSel` stays 0 and the full 8-bit written value is stored as the bank.
- R11: Qualified writes outside 0x6000-0x7FFF change no bank register and no RAM mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWide | input | 1 | 1 selects the 16KB arrangement, 0 the 8KB one |
| cfgSramEn | input | 1 | 1 enables the battery RAM select |
| slotSel | input | 1 | Cartridge slot is addressed |
| cpuWr | input | 1 | CPU write strobe |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| romAddr | output | 21 | {bank, offset} ROM address |
| sramSel | output | 1 | Current access goes to RAM instead of ROM |
| sramWe | output | 1 | RAM write enable |

## Verification
The bench sweeps every byte value into every bank register under both arrangements, and predicts each window address arithmetically.
- A decoder that drops address bit 11 would alias window pairs.
- An error in the 16KB pair load would show an odd first bank, or a second bank off by more than one.
- Nibble masking and RAM flag handling are checked through the RAM-enabled flows. A mapper that kept the full byte, or that mapped the 0xA000 window to RAM in the 16KB arrangement, gives a wrong `romAddr` or `sramSel`.
- Unqualified writes, writes outside the register range, and the ignored 16KB addresses are each followed by a read of all windows, so that a register changed by mistake shows up.

// File: rtl/asc_map_pkg.sv
package asc_map_pkg;
  localparam int BANK_W   = 8;
  localparam int OFS_W    = 13;
  localparam int NUM_WIN  = 4;
  localparam int SRAM_WIN = 2;

  // Strobes from the write decoder to the mapping registers
  typedef struct packed {
    logic [NUM_WIN-1:0]             bankLoad;
    logic [NUM_WIN-1:0][BANK_W-1:0] bankVal;
    logic [SRAM_WIN-1:0]            flagLoad;
    logic [SRAM_WIN-1:0]            flagVal;
  } mapStrobe_t;
endpackage

// File: rtl/bank_mapper_ctrl.sv
module bank_mapper_ctrl
  import asc_map_pkg::*;
(
  input  logic        cfgWide,
  input  logic        cfgSramEn,
  input  logic        slotSel,
  input  logic        cpuWr,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  output mapStrobe_t  strobe
);
  logic              regWr;
  logic [1:0]        sub;
  logic [BANK_W-1:0] val;
  logic [1:0]        idx;

  assign regWr = cpuWr && slotSel && (cpuAddr[15:13] == 3'b011);
  assign sub   = cpuAddr[12:11];
  // R7: with RAM enabled only the low nibble is a bank number
  assign val   = cfgSramEn ? {4'b0000, cpuWrData[3:0]} : cpuWrData;

  always_comb begin
    strobe = '0;
    idx    = '0;
    if (regWr) begin
      if (!cfgWide) begin
        strobe.bankLoad[sub] = 1'b1;
        strobe.bankVal[sub]  = val;
        if (cfgSramEn && sub[1]) begin
          strobe.flagLoad = '1;
          strobe.flagVal  = {SRAM_WIN{|cpuWrData[7:4]}};
        end
      end else if (!sub[0]) begin
        for (int i = 0; i < 2; i++) begin
          idx = {sub[1], i[0]};
          strobe.bankLoad[idx] = 1'b1;
          strobe.bankVal[idx]  = {val[BANK_W-2:0], i[0]};
        end
        if (cfgSramEn && sub[1]) begin
          strobe.flagLoad = '1;
          strobe.flagVal  = {1'b0, cpuWrData[4]};
        end
      end
    end
  end
endmodule

// File: rtl/bank_mapper_dp.sv
module bank_mapper_dp
  import asc_map_pkg::*;
#(
  parameter int ROM_BANKS = 32
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  mapStrobe_t                  strobe,
  input  logic                        cfgSramEn,
  input  logic                        slotSel,
  input  logic                        cpuWr,
  input  logic [15:0]                 cpuAddr,
  output logic [BANK_W+OFS_W-1:0]     romAddr,
  output logic                        sramSel,
  output logic                        sramWe,
  output logic [NUM_WIN-1:0][BANK_W-1:0] bankQ,
  output logic [SRAM_WIN-1:0]         flagQ
);
  localparam logic [BANK_W-1:0] BANK_MASK = BANK_W'(ROM_BANKS - 1);

  logic       inRange;
  logic [1:0] win;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)                  bankQ[w] <= '0;
      else if (strobe.bankLoad[w]) bankQ[w] <= strobe.bankVal[w];
    end
  end

  for (genvar s = 0; s < SRAM_WIN; s++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                  flagQ[s] <= 1'b0;
      else if (strobe.flagLoad[s]) flagQ[s] <= strobe.flagVal[s];
    end
  end

  assign inRange = cpuAddr[15] ^ cpuAddr[14];
  assign win     = {cpuAddr[15], cpuAddr[13]};

  assign romAddr = inRange ? {bankQ[win] & BANK_MASK, cpuAddr[OFS_W-1:0]}
                           : {{BANK_W{1'b0}}, cpuAddr[OFS_W-1:0]};
  assign sramSel = slotSel && cfgSramEn && inRange && cpuAddr[15] && flagQ[cpuAddr[13]];
  assign sramWe  = sramSel && cpuWr;
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import asc_map_pkg::*;
#(
  parameter int ROM_BANKS = 32
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWide,
  input  logic                    cfgSramEn,
  input  logic                    slotSel,
  input  logic                    cpuWr,
  input  logic [15:0]             cpuAddr,
  input  logic [7:0]              cpuWrData,
  output logic [BANK_W+OFS_W-1:0] romAddr,
  output logic                    sramSel,
  output logic                    sramWe
);
  mapStrobe_t                     strobe;
  logic [NUM_WIN-1:0][BANK_W-1:0] bankQ;
  logic [SRAM_WIN-1:0]            flagQ;

  bank_mapper_ctrl u_ctrl (
    .cfgWide(cfgWide), .cfgSramEn(cfgSramEn), .slotSel(slotSel), .cpuWr(cpuWr),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .strobe(strobe)
  );

  bank_mapper_dp #(.ROM_BANKS(ROM_BANKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgSramEn(cfgSramEn),
    .slotSel(slotSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .romAddr(romAddr),
    .sramSel(sramSel), .sramWe(sramWe), .bankQ(bankQ), .flagQ(flagQ)
  );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
  import asc_map_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           cfgWide,
  input logic                           cfgSramEn,
  input logic                           slotSel,
  input logic                           cpuWr,
  input logic [15:0]                    cpuAddr,
  input logic                           sramSel,
  input logic                           sramWe,
  input logic [NUM_WIN-1:0][BANK_W-1:0] bankQ,
  input logic [SRAM_WIN-1:0]            flagQ
);
  a_r3_unqualified_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWr && slotSel) |=> ($stable(bankQ) && $stable(flagQ)));

  a_r11_outside_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && slotSel && cpuAddr[15:13] != 3'b011) |=> ($stable(bankQ) && $stable(flagQ)));

  a_r5_pair_load: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && slotSel && cfgWide && cpuAddr[15:11] == 5'b01100)
      |=> (bankQ[1] == bankQ[0] + 8'd1 && !bankQ[0][0]));

  a_r6_ignored_odd: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && slotSel && cfgWide && cpuAddr[15:13] == 3'b011 && cpuAddr[11])
      |=> ($stable(bankQ) && $stable(flagQ)));

  a_r9_we_gate: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (sramSel && cpuWr && slotSel));

  a_r7_upper_half: assert property (@(posedge clk) disable iff (!rstN)
    sramSel |-> (cpuAddr[15:14] == 2'b10));

  a_r10_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSramEn |-> !sramSel);
endmodule

bind bank_mapper bank_mapper_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWide(cfgWide), .cfgSramEn(cfgSramEn),
  .slotSel(slotSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .sramSel(sramSel),
  .sramWe(sramWe), .bankQ(bankQ), .flagQ(flagQ)
);

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;
  localparam int ROM_BANKS = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWide = 1'b0;
  logic        cfgSramEn = 1'b0;
  logic        slotSel = 1'b1;
  logic        cpuWr = 1'b0;
  logic [15:0] cpuAddr = 16'h0;
  logic [7:0]  cpuWrData = 8'h0;
  logic [20:0] romAddr;
  logic        sramSel;
  logic        sramWe;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expBank [4];
  logic       expFlag [2];

  bank_mapper #(.ROM_BANKS(ROM_BANKS)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWide(cfgWide), .cfgSramEn(cfgSramEn),
    .slotSel(slotSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .romAddr(romAddr), .sramSel(sramSel), .sramWe(sramWe)
  );

  always #10 clk = ~clk;

  task automatic report(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model update, written from the requirements
  task automatic modelWrite(input logic [15:0] a, input logic [7:0] d, input logic slot);
    logic [7:0] v;
    logic [1:0] sub;
    if (!slot || a[15:13] != 3'b011) return;
    sub = a[12:11];
    v = cfgSramEn ? {4'h0, d[3:0]} : d;
    if (!cfgWide) begin
      expBank[sub] = v;
      if (cfgSramEn && sub[1]) begin
        expFlag[0] = (d[7:4] != 0);
        expFlag[1] = (d[7:4] != 0);
      end
    end else if (!sub[0]) begin
      expBank[2*sub[1]]   = 8'(v * 2);
      expBank[2*sub[1]+1] = 8'(v * 2 + 1);
      if (cfgSramEn && sub[1]) begin
        expFlag[0] = d[4];
        expFlag[1] = 1'b0;
      end
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic slot);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWr = 1'b1; slotSel = slot;
    @(negedge clk);
    cpuWr = 1'b0; slotSel = 1'b1;
    modelWrite(a, d, slot);
  endtask

  task automatic checkOut(input logic [15:0] a, input string req);
    logic [20:0] eAddr;
    logic        eSram;
    logic        inR;
    @(negedge clk);
    cpuAddr = a; cpuWr = 1'b0; slotSel = 1'b1;
    #2;
    inR = a[15] ^ a[14];
    eAddr = inR ? {expBank[{a[15], a[13]}] & 8'(ROM_BANKS - 1), a[12:0]} : {8'h00, a[12:0]};
    eSram = cfgSramEn && inR && a[15] && expFlag[a[13]];
    report(req, (romAddr === eAddr) && (sramSel === eSram), {10'h0, sramSel, romAddr}, {10'h0, eSram, eAddr});
  endtask

  task automatic checkAll(input string req);
    for (int w = 0; w < 4; w++) checkOut(16'h4000 + 16'(w) * 16'h2000 + 16'h0A5, req);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) expBank[i] = 8'h00;
    expFlag[0] = 1'b0; expFlag[1] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkAll("R1");
    checkOut(16'hBFFF, "R1");

    // R2 R4 R10: 8KB arrangement, every value into every register
    for (int w = 0; w < 4; w++) begin
      for (int v = 0; v < 256; v++) begin
        wr(16'h6000 + 16'(w) * 16'h0800 + 16'((v * 13) & 16'h7FF), 8'(v), 1'b1);
        checkOut(16'h4000 + 16'(w) * 16'h2000 + 16'((v * 37) & 16'h1FFF), "R2_R4_R10");
        checkOut(16'h4000 + 16'((w + 1) % 4) * 16'h2000 + 16'h1FFF, "R2");
      end
    end
    wr(16'h6000, 8'h11, 1'b1); wr(16'h6800, 8'h12, 1'b1);
    wr(16'h7000, 8'hF3, 1'b1); wr(16'h7800, 8'h94, 1'b1);
    checkAll("R2_R10");

    // R3 unqualified writes
    wr(16'h6000, 8'h55, 1'b0);
    wr(16'h7800, 8'h66, 1'b0);
    @(negedge clk); cpuAddr = 16'h6800; cpuWrData = 8'h77; slotSel = 1'b1; cpuWr = 1'b0;
    checkAll("R3");

    // R11 writes outside the register range
    wr(16'h5000, 8'hAA, 1'b1); wr(16'h8000, 8'hBB, 1'b1);
    wr(16'h0000, 8'hCC, 1'b1); wr(16'hC000, 8'hDD, 1'b1);
    checkAll("R11");

    // R4 outside the slot range
    checkOut(16'h0123, "R4"); checkOut(16'hC456, "R4");
    checkOut(16'hFFFF, "R4"); checkOut(16'h3FFF, "R4");

    // R5 R6 16KB arrangement
    cfgWide = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(16'h6000 + 16'(v & 16'h7FF), 8'(v), 1'b1);
      checkOut(16'h4010, "R5"); checkOut(16'h7FF0, "R5");
      wr(16'h7000 + 16'((v * 5) & 16'h7FF), 8'(255 - v), 1'b1);
      checkOut(16'h8001, "R6"); checkOut(16'hA001, "R6");
    end
    wr(16'h6800, 8'h3C, 1'b1); wr(16'h7800, 8'h5A, 1'b1); wr(16'h6FFF, 8'h01, 1'b1);
    checkAll("R6_ignored");

    // R7 RAM in the 8KB arrangement
    cfgWide = 1'b0; cfgSramEn = 1'b1;
    wr(16'h7000, 8'h35, 1'b1);
    checkAll("R7");
    checkOut(16'hBFFF, "R7");
    wr(16'h7800, 8'h07, 1'b1);
    checkAll("R7");
    wr(16'h7800, 8'h80, 1'b1);
    checkAll("R7");
    for (int v = 0; v < 256; v++) begin
      wr(16'h6000, 8'(v), 1'b1);
      checkOut(16'h4100, "R7_mask");
    end

    // R9 RAM write enable at the ports
    @(negedge clk); cpuAddr = 16'h8123; cpuWr = 1'b1; slotSel = 1'b1; #2;
    report("R9", sramWe === 1'b1, {31'h0, sramWe}, 32'h1);
    cpuAddr = 16'hA456; #2;
    report("R9", sramWe === 1'b1, {31'h0, sramWe}, 32'h1);
    cpuAddr = 16'h4123; #2;
    report("R9", sramWe === 1'b0, {31'h0, sramWe}, 32'h0);
    cpuAddr = 16'h8123; slotSel = 1'b0; #2;
    report("R9", (sramWe === 1'b0) && (sramSel === 1'b0), {30'h0, sramSel, sramWe}, 32'h0);
    @(negedge clk); cpuWr = 1'b0; slotSel = 1'b1; cpuAddr = 16'h8123; #2;
    report("R9", (sramWe === 1'b0) && (sramSel === 1'b1), {30'h0, sramSel, sramWe}, 32'h2);
    checkAll("R9_R11");

    // R8 RAM in the 16KB arrangement
    cfgWide = 1'b1;
    wr(16'h7000, 8'h13, 1'b1);
    checkAll("R8");
    wr(16'h7000, 8'hE2, 1'b1);
    checkAll("R8");
    wr(16'h7000, 8'h1F, 1'b1);
    checkOut(16'h9FFF, "R8"); checkOut(16'hA000, "R8");

    // R10 RAM disabled hides the flag
    cfgSramEn = 1'b0;
    checkAll("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule